// File: doc/BRIEF.md
# Dedicated Input Sampler with Per-Channel Interrupts

This block watches a bank of input channels that come straight from pads. Each channel passes through a two-flop synchroniser and then a delay stage of 0 to 3 clock cycles, set per channel by software. After the delay, each channel goes to a condition detector. The detector can look for a rising edge, a falling edge, either edge, a low level or a high level. Detections on enabled channels set sticky status bits. A single interrupt line is the OR of all status bits.

Software uses a simple synchronous register port with separate write and read addresses. It programs the delay word and the trigger-type word. It sets or clears enable bits through two separate addresses, so it never has to read, modify and write the mask. It reads back the status word and the delayed input levels. It clears status bits by writing a mask. Read data is registered and appears one clock after the read address. All state resets to zero on a synchronous active-high reset.

Top module: `gpin_irq_bank`

## Requirements
- R1: The delayed level of channel n reaches the input readout (read address 5, bit n) exactly 3+D clocks after the pin changes. Here D is the 2-bit field at bits [2n+1:2n] of the delay word (address 0). The count is 2 synchroniser stages, then D delay stages, then the read register.
- R2: The delay word (address 0), trigger word (address 1) and enable mask (read at address 2) read back as written. `rd_data` shows the value selected by `rd_addr` one clock after the address is presented. Addresses that cannot be read return zero.
- R3: Channel n uses the 3-bit code at bits [3n+2:3n] of the trigger word. The codes are: 0 none, 1 rising edge, 2 falling edge, 3 either edge, 4 low level, 5 high level. Codes 6 and 7 act as none.
- R4: A write to address 2 sets the enable bits where `wr_data` is 1, and a write to address 3 clears them. No other enable bits change. A channel whose enable bit is 0 never sets its status bit.
- R5: Once set, a status bit stays set until it is cleared, even after the input returns to its earlier level.
- R6: A write to address 4 clears exactly the status bits whose `wr_data` bit is 1. The status word is read at address 4, one bit per channel.
- R7: While a level condition holds, the channel sets its status bit on every cycle. When a detection and a clear hit the same channel in the same cycle, the bit stays set.
- R8: `irq` is registered and always equals the OR of the current status bits.
- R9: After reset, all configuration, status, `irq` and `rd_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NCH | Asynchronous channel inputs |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| rd_addr | input | AW | Read address |
| rd_data | output | DW | Registered read data |
| irq | output | 1 | Combined interrupt, OR of status |

## Verification
Assertions check four things on every cycle:
- a status bit never rises on a disabled channel;
- a status bit never falls unless it was in a clear mask that cycle;
- a cleared bit stays clear unless a detection arrived in the same cycle;
- `irq` always matches the status word.

Only the bench's scenarios can show the rest:
- that each trigger code picks the right condition;
- that the programmed delay shifts the input by the exact cycle count;
- that a held level survives a clear and drops once the level is released.

// File: rtl/gpin_pkg.sv
package gpin_pkg;
  typedef enum logic [2:0] {
    TRIG_NONE = 3'd0,
    TRIG_RISE = 3'd1,
    TRIG_FALL = 3'd2,
    TRIG_BOTH = 3'd3,
    TRIG_LOW  = 3'd4,
    TRIG_HIGH = 3'd5
  } trig_e;

  localparam int TRIG_W = 3;
  localparam int DLY_W  = 2;

  localparam logic [2:0] ADDR_DELAY  = 3'd0;
  localparam logic [2:0] ADDR_TRIG   = 3'd1;
  localparam logic [2:0] ADDR_EN_SET = 3'd2;
  localparam logic [2:0] ADDR_EN_CLR = 3'd3;
  localparam logic [2:0] ADDR_STAT   = 3'd4;
  localparam logic [2:0] ADDR_LEVEL  = 3'd5;
endpackage

// File: rtl/gpin_sync.sv
module gpin_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
    end
  end

  assign dout = sync_q;
endmodule

// File: rtl/gpin_delay.sv
module gpin_delay #(
  parameter int W    = 8,
  parameter int MAXD = 3,
  parameter int SELW = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [W-1:0]    din,
  input  logic [W*SELW-1:0] sel,
  output logic [W-1:0]    dout
);
  logic [W-1:0] stage_q [1:MAXD];

  for (genvar k = 1; k <= MAXD; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        stage_q[k] <= '0;
      end else if (k == 1) begin
        stage_q[k] <= din;
      end else begin
        stage_q[k] <= stage_q[(k > 1) ? k-1 : 1];
      end
    end
  end

  for (genvar n = 0; n < W; n++) begin : g_tap
    logic [SELW-1:0] s;
    assign s = sel[n*SELW +: SELW];
    always_comb begin
      dout[n] = din[n];
      for (int k = 1; k <= MAXD; k++) begin
        if (int'(s) == k || (k == MAXD && int'(s) > MAXD)) begin
          dout[n] = stage_q[k][n];
        end
      end
    end
  end
endmodule

// File: rtl/gpin_detect.sv
module gpin_detect
  import gpin_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [W-1:0]      cur,
  input  logic [W*TRIG_W-1:0] trig,
  output logic [W-1:0]      hit
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= cur;
  end

  for (genvar n = 0; n < W; n++) begin : g_ch
    logic [TRIG_W-1:0] code;
    logic rise, fall;
    assign code = trig[n*TRIG_W +: TRIG_W];
    assign rise = cur[n] & ~prev_q[n];
    assign fall = ~cur[n] & prev_q[n];
    always_comb begin
      case (code)
        TRIG_RISE: hit[n] = rise;
        TRIG_FALL: hit[n] = fall;
        TRIG_BOTH: hit[n] = rise | fall;
        TRIG_LOW:  hit[n] = ~cur[n];
        TRIG_HIGH: hit[n] = cur[n];
        default:   hit[n] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/gpin_irq_bank.sv
module gpin_irq_bank
  import gpin_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int AW   = 3,
  parameter int DW   = 32,
  parameter int MAXD = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] pin_i,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic [AW-1:0]  rd_addr,
  output logic [DW-1:0]  rd_data,
  output logic           irq
);
  localparam int DLYW  = NCH * DLY_W;
  localparam int TRGW  = NCH * TRIG_W;

  logic [DLYW-1:0] dly_q;
  logic [TRGW-1:0] trig_q;
  logic [NCH-1:0]  en_q;
  logic [NCH-1:0]  status_q;
  logic [NCH-1:0]  status_nxt;
  logic [NCH-1:0]  synced;
  logic [NCH-1:0]  delayed;
  logic [NCH-1:0]  hit;
  logic [NCH-1:0]  hit_en;
  logic [NCH-1:0]  clr_mask;
  logic [DW-1:0]   rd_nxt;

  gpin_sync #(.W(NCH)) u_sync (
    .clk(clk), .rst(rst), .din(pin_i), .dout(synced)
  );

  gpin_delay #(.W(NCH), .MAXD(MAXD), .SELW(DLY_W)) u_delay (
    .clk(clk), .rst(rst), .din(synced), .sel(dly_q), .dout(delayed)
  );

  gpin_detect #(.W(NCH)) u_detect (
    .clk(clk), .rst(rst), .cur(delayed), .trig(trig_q), .hit(hit)
  );

  // Configuration registers and enable mask.
  always_ff @(posedge clk) begin
    if (rst) begin
      dly_q  <= '0;
      trig_q <= '0;
      en_q   <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        AW'(ADDR_DELAY):  dly_q  <= wr_data[DLYW-1:0];
        AW'(ADDR_TRIG):   trig_q <= wr_data[TRGW-1:0];
        AW'(ADDR_EN_SET): en_q   <= en_q | wr_data[NCH-1:0];
        AW'(ADDR_EN_CLR): en_q   <= en_q & ~wr_data[NCH-1:0];
        default: ;
      endcase
    end
  end

  // Sticky status: a detection in the same cycle beats a clear.
  assign hit_en     = hit & en_q;
  assign clr_mask   = (wr_en && wr_addr == AW'(ADDR_STAT)) ? wr_data[NCH-1:0] : '0;
  assign status_nxt = (status_q & ~clr_mask) | hit_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      irq      <= 1'b0;
    end else begin
      status_q <= status_nxt;
      irq      <= |status_nxt;
    end
  end

  // Registered read port.
  always_comb begin
    rd_nxt = '0;
    case (rd_addr)
      AW'(ADDR_DELAY):  rd_nxt[DLYW-1:0] = dly_q;
      AW'(ADDR_TRIG):   rd_nxt[TRGW-1:0] = trig_q;
      AW'(ADDR_EN_SET): rd_nxt[NCH-1:0]  = en_q;
      AW'(ADDR_STAT):   rd_nxt[NCH-1:0]  = status_q;
      AW'(ADDR_LEVEL):  rd_nxt[NCH-1:0]  = delayed;
      default:          rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_nxt;
  end

  // Checks beside the status logic.
  assert_gate_R4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(en_q)) == '0))
    else $error("status rose on a disabled channel");

  assert_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(status_q) & ~$past(clr_mask) & ~status_q) == '0))
    else $error("status fell without a clear");

  assert_w1c_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == AW'(ADDR_STAT)) |=>
      ((status_q & $past(wr_data[NCH-1:0] & ~hit_en)) == '0))
    else $error("cleared status bit survived without a detection");

  assert_irq_R8: assert property (@(posedge clk) disable iff (rst)
    irq == (|status_q))
    else $error("irq disagrees with status");
endmodule

// File: tb/tb_gpin_irq_bank.sv
module tb_gpin_irq_bank;
  localparam int NCH = 8;
  localparam int AW  = 3;
  localparam int DW  = 32;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NCH-1:0] pin_i = '0;
  logic           wr_en = 1'b0;
  logic [AW-1:0]  wr_addr = '0;
  logic [DW-1:0]  wr_data = '0;
  logic [AW-1:0]  rd_addr = '0;
  logic [DW-1:0]  rd_data;
  logic           irq;

  int applied = 0;
  int miscmp  = 0;
  bit done    = 1'b0;

  gpin_irq_bank #(.NCH(NCH), .AW(AW), .DW(DW)) dut (
    .clk(clk), .rst(rst), .pin_i(pin_i), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  always #5 clk = ~clk;

  // {code, pins before, pins after, expected status}
  localparam logic [26:0] VEC [0:8] = '{
    {3'd1, 8'h0F, 8'h3C, 8'h30},
    {3'd2, 8'h0F, 8'h3C, 8'h03},
    {3'd3, 8'hA5, 8'h5A, 8'hFF},
    {3'd4, 8'hF0, 8'hCC, 8'h3F},
    {3'd5, 8'hF0, 8'hCC, 8'hFC},
    {3'd0, 8'h00, 8'hFF, 8'h00},
    {3'd6, 8'h00, 8'hFF, 8'h00},
    {3'd7, 8'hFF, 8'h00, 8'h00},
    {3'd3, 8'h00, 8'h00, 8'h00}
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step(1);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a);
    rd_addr = a;
    step(1);
  endtask

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    applied++;
    if (act !== exp) begin
      miscmp++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscmp);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscmp++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);

    // R9: reset state
    check("R9 irq", {31'd0, irq}, 32'd0);
    rd(3'd0); check("R9 delay", rd_data, 32'd0);
    rd(3'd1); check("R9 trig", rd_data, 32'd0);
    rd(3'd2); check("R9 enable", rd_data, 32'd0);
    rd(3'd4); check("R9 status", rd_data, 32'd0);

    // R4: enable set and clear touch only masked bits
    wr(3'd2, 32'h0F);
    wr(3'd2, 32'hF0);
    rd(3'd2); check("R4 set", rd_data, 32'hFF);
    wr(3'd3, 32'h3C);
    rd(3'd2); check("R4 clear", rd_data, 32'hC3);

    // R2: configuration readback and read-only/unused address
    wr(3'd1, 32'h00FAC688);
    rd(3'd1); check("R2 trig", rd_data, 32'h00FAC688);
    wr(3'd0, 32'h0000000C);
    rd(3'd0); check("R2 delay", rd_data, 32'h0000000C);
    rd(3'd7); check("R2 unused", rd_data, 32'd0);

    // R1: ch0 delay 0, ch1 delay 3, exact arrival cycle
    wr(3'd1, 32'd0);
    rd_addr = 3'd5;
    step(8);
    pin_i = 8'h03;
    step(2); check("R1 ch0 early", {31'd0, rd_data[0]}, 32'd0);
    step(1); check("R1 ch0 on time", {31'd0, rd_data[0]}, 32'd1);
    step(2); check("R1 ch1 early", {31'd0, rd_data[1]}, 32'd0);
    step(1); check("R1 ch1 on time", {31'd0, rd_data[1]}, 32'd1);
    wr(3'd0, 32'd0);
    pin_i = 8'h00;
    step(8);

    // R4, R5: disabled channels stay clear; status sticks after pins return
    wr(3'd1, 32'h00249249);
    wr(3'd4, 32'hFF);
    pin_i = 8'hFF;
    step(6);
    pin_i = 8'h00;
    step(6);
    rd(3'd4); check("R4 gated rise", rd_data, 32'hC3);
    check("R5 sticky", rd_data, 32'hC3);
    check("R8 irq set", {31'd0, irq}, 32'd1);

    // R6: partial write-one-to-clear
    wr(3'd4, 32'h41);
    rd(3'd4); check("R6 partial", rd_data, 32'h82);
    check("R8 irq held", {31'd0, irq}, 32'd1);
    wr(3'd4, 32'h82);
    rd(3'd4); check("R6 rest", rd_data, 32'h00);
    check("R8 irq drop", {31'd0, irq}, 32'd0);

    // R7: held high level survives clear, drops after release
    wr(3'd2, 32'hFF);
    wr(3'd1, 32'h00000005);
    pin_i = 8'h01;
    step(6);
    wr(3'd4, 32'h01);
    rd(3'd4); check("R7 detect wins", rd_data, 32'h01);
    pin_i = 8'h00;
    step(6);
    wr(3'd4, 32'h01);
    rd(3'd4); check("R7 released", rd_data, 32'h00);

    // R3: trigger codes over all channels, table-driven
    for (int i = 0; i < 9; i++) begin
      logic [2:0] code;
      logic [7:0] bfr, aft, exp;
      {code, bfr, aft, exp} = VEC[i];
      wr(3'd1, {8'h00, {8{code}}});
      pin_i = bfr;
      step(6);
      wr(3'd4, 32'hFF);
      pin_i = aft;
      step(6);
      rd(3'd4);
      check($sformatf("R3 code %0d", code), rd_data, {24'd0, exp});
      check("R8 irq vs status", {31'd0, irq}, {31'd0, |exp});
    end

    finish_run();
  end
endmodule